// File: doc/BRIEF.md
# Lockstep Replay Delay Buffer

This block sits between a leading processor's bus and a trailing shadow processor that runs the same program. On every bus cycle the leader completes, the block records the read data and the number of wait states that cycle took. It hands the same results to the shadow side a programmable number of cycles later. The shadow therefore re-executes the same instruction stream one or more whole instructions behind the leader. That lag must cover the longest instruction (roughly 60 cycles) and, with prefetch pipelining, up to about four instructions (roughly 240 cycles).

The delay is set in clock cycles on `lag_sel`. An entry becomes eligible for replay only once it has aged by that many cycles. When an entry is loaded into the output stage, the replay port first keeps `rep_valid` low for the recorded number of wait states, then presents the data under a valid/ready handshake. A flush discards everything outstanding and restarts the ageing, for use when the leader takes a fault. A capture that finds the storage full is dropped and raises a sticky overflow flag.

Top module: `lag_replay_buf`

## Requirements
- R1: Every accepted capture appears on the replay port exactly once, in capture order, with its data unchanged. `rep_valid` is never high while no accepted entry is outstanding.
- R2: A capture sampled at clock edge k (cap_valid high at that edge), with lag L on lag_sel (0 to 255), zero wait states and a free output stage, first shows rep_valid high right after edge k+L+1.
- R3: An entry with a recorded wait count w (cap_wait, 0 to 15) keeps rep_valid low for w cycles after it is loaded. In general its first valid edge is max(k+L+1, A)+w, where A is the edge at which the previous entry was accepted, or the last flush or reset edge.
- R4: When the next entry is already eligible at the edge its predecessor is accepted and has zero wait, rep_valid stays high with the new data from that edge on, with no idle cycle.
- R5: While rep_valid is high and rep_ready is low, rep_valid stays high and rep_data does not change in the next cycle.
- R6: The block holds DEPTH entries in storage plus one in the output stage. A capture arriving while storage is full is dropped. overflow goes high after that edge and stays high through later flushes until reset.
- R7: After an edge with flush high, rep_valid is low, all outstanding entries are discarded, a capture in the same cycle is discarded, and new captures age from the point they are captured.
- R8: After an edge with rst high, rep_valid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Leader bus cycle completed; record this result |
| cap_data | input | DATA_W | Read data of the completed bus cycle |
| cap_wait | input | WAIT_W | Wait states the bus cycle took |
| lag_sel | input | LAG_W | Replay lag in clock cycles; change only together with a flush |
| flush | input | 1 | Discard all outstanding entries and restart ageing |
| rep_ready | input | 1 | Shadow side accepts the presented entry |
| rep_valid | output | 1 | Replay entry presented (registered) |
| rep_data | output | DATA_W | Replayed read data (registered) |
| overflow | output | 1 | Sticky flag: a capture was dropped because storage was full |

## Verification
Each entry's first valid cycle is exact: it is max(k+L+1, A)+w edges, with k the capture edge, L the lag, A the predecessor's acceptance edge and w its wait count. The bench computes this edge from its own record of capture and acceptance edges. It checks rep_valid in the same cycle and fails if the entry shows up even one cycle early or late. overflow is due right after the edge of the dropped capture, and rep_valid must be low right after a flush or reset edge. Inputs are driven and outputs sampled on the falling edge, so each sample reads the registers that the preceding rising edge has just updated.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  // Output stage condition of the replay side
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,  // nothing loaded
    ST_HOLD  = 2'd1,  // loaded, replaying wait states
    ST_SHOW  = 2'd2   // data presented, waiting for ready
  } rel_state_e;

endpackage

// File: rtl/lrb_store.sv
// Capture storage: data words in a block-RAM style array with a registered
// read port, wait counts in a small array read combinationally.
module lrb_store #(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [WAIT_W-1:0] push_wait,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [WAIT_W-1:0] head_wait,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [WAIT_W-1:0] wait_mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  // data array write port
  always_ff @(posedge clk) begin
    if (push) data_mem[wr_ptr] <= push_data;
  end

  // wait-count array write port
  always_ff @(posedge clk) begin
    if (push) wait_mem[wr_ptr] <= push_wait;
  end

  // registered read port, doubles as the replay data register
  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= data_mem[rd_ptr];
  end

  assign head_wait = wait_mem[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/lrb_age_line.sv
// Ageing line: one bit per cycle marks an accepted capture; the bit at the
// selected tap marks the moment that capture has aged by the programmed lag.
module lrb_age_line #(
  parameter int LAG_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             enter,
  input  logic [LAG_W-1:0] lag,
  input  logic             take,
  output logic             avail,
  output logic [CNT_W-1:0] vis_count
);

  localparam int TAPS = 1 << LAG_W;

  logic [TAPS-1:0]  marks;
  logic [LAG_W-1:0] tap_idx;
  logic             emerge;

  assign tap_idx = lag - 1'b1;
  assign emerge  = (lag == '0) ? enter : marks[tap_idx];
  assign avail   = (vis_count != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) marks <= '0;
    else              marks <= {marks[TAPS-2:0], enter};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vis_count <= '0;
    end else begin
      case ({emerge, take})
        2'b10:   vis_count <= vis_count + 1'b1;
        2'b01:   vis_count <= vis_count - 1'b1;
        default: vis_count <= vis_count;
      endcase
    end
  end

endmodule

// File: rtl/lrb_release.sv
// Output stage control: loads an eligible entry, replays its wait states by
// holding valid low, then presents it until the shadow side accepts.
module lrb_release
  import lrb_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              avail,
  input  logic [WAIT_W-1:0] head_wait,
  input  logic              rep_ready,
  output logic              load,
  output logic              rep_valid
);

  rel_state_e        state;
  logic [WAIT_W-1:0] hold_left;
  logic              stage_free;

  assign stage_free = (state == ST_EMPTY) || ((state == ST_SHOW) && rep_ready);
  assign load       = stage_free && avail && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state     <= ST_EMPTY;
      rep_valid <= 1'b0;
      hold_left <= '0;
    end else if (load) begin
      if (head_wait == '0) begin
        state     <= ST_SHOW;
        rep_valid <= 1'b1;
      end else begin
        state     <= ST_HOLD;
        rep_valid <= 1'b0;
        hold_left <= head_wait;
      end
    end else if ((state == ST_SHOW) && rep_ready) begin
      state     <= ST_EMPTY;
      rep_valid <= 1'b0;
    end else if (state == ST_HOLD) begin
      if (hold_left == WAIT_W'(1)) begin
        state     <= ST_SHOW;
        rep_valid <= 1'b1;
      end
      hold_left <= hold_left - 1'b1;
    end
  end

endmodule

// File: rtl/lag_replay_buf.sv
module lag_replay_buf #(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  parameter int DEPTH  = 256,
  parameter int LAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [WAIT_W-1:0] cap_wait,
  input  logic [LAG_W-1:0]  lag_sel,
  input  logic              flush,
  input  logic              rep_ready,
  output logic              rep_valid,
  output logic [DATA_W-1:0] rep_data,
  output logic              overflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              full;
  logic              cap_ok;
  logic              load;
  logic              avail;
  logic [WAIT_W-1:0] head_wait;
  logic [CNT_W-1:0]  mem_count;
  logic [CNT_W-1:0]  vis_count;

  assign cap_ok = cap_valid && !flush && !full;

  lrb_store #(
    .DATA_W(DATA_W), .WAIT_W(WAIT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .push(cap_ok), .push_data(cap_data), .push_wait(cap_wait),
    .pop(load), .rd_data(rep_data), .head_wait(head_wait),
    .count(mem_count), .full(full)
  );

  lrb_age_line #(
    .LAG_W(LAG_W), .CNT_W(CNT_W)
  ) u_age (
    .clk(clk), .rst(rst), .flush(flush),
    .enter(cap_ok), .lag(lag_sel), .take(load),
    .avail(avail), .vis_count(vis_count)
  );

  lrb_release #(
    .WAIT_W(WAIT_W)
  ) u_rel (
    .clk(clk), .rst(rst), .flush(flush),
    .avail(avail), .head_wait(head_wait), .rep_ready(rep_ready),
    .load(load), .rep_valid(rep_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)                                overflow <= 1'b0;
    else if (cap_valid && !flush && full)   overflow <= 1'b1;
  end

endmodule

// File: rtl/lrb_chk.sv
module lrb_chk #(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic [DATA_W-1:0] rep_data,
  input logic              overflow,
  input logic              load,
  input logic [WAIT_W-1:0] head_wait,
  input logic [CNT_W-1:0]  mem_count,
  input logic [CNT_W-1:0]  vis_count
);

  // R1
  visible_le_stored_chk: assert property (@(posedge clk) disable iff (rst)
    vis_count <= mem_count);

  // R3
  wait_hides_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !flush && head_wait != '0) |=> !rep_valid);

  // R5
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && !rep_ready && !flush) |=> (rep_valid && $stable(rep_data)));

  // R6
  storage_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mem_count <= CNT_W'(DEPTH));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !rep_valid);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rep_valid && !overflow));

endmodule

bind lag_replay_buf lrb_chk #(
  .DATA_W(DATA_W), .WAIT_W(WAIT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush),
  .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_data(rep_data),
  .overflow(overflow), .load(load), .head_wait(head_wait),
  .mem_count(mem_count), .vis_count(vis_count)
);

// File: tb/test_lag_replay_buf.sv
`timescale 1ns/1ps
module test_lag_replay_buf;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic        cap_valid;
  logic [15:0] cap_data;
  logic [3:0]  cap_wait;
  logic [7:0]  lag_sel;
  logic        flush;
  logic        rep_ready;
  logic        rep_valid;
  logic [15:0] rep_data;
  logic        overflow;

  lag_replay_buf #(.DATA_W(16), .WAIT_W(4), .DEPTH(DEPTH), .LAG_W(8)) i_lag_replay_buf (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_wait(cap_wait), .lag_sel(lag_sel), .flush(flush),
    .rep_ready(rep_ready), .rep_valid(rep_valid), .rep_data(rep_data),
    .overflow(overflow)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk  = 0;
  int nfail = 0;
  int q_d[$];
  int q_w[$];
  int q_k[$];
  bit head_seen = 1'b0;
  int a_prev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int first_valid_edge();
    int base;
    base = q_k[0] + int'(lag_sel) + 1;
    if (a_prev > base) base = a_prev;
    return base + q_w[0];
  endfunction

  task automatic check_outputs();
    int    v;
    string tag;
    if (q_d.size() == 0) begin
      if (rep_valid) check(1'b0, "R1", "valid with nothing outstanding", 1, 0);
    end else if (!head_seen) begin
      v   = first_valid_edge();
      tag = (q_w[0] != 0) ? "R3" :
            ((a_prev > q_k[0] + int'(lag_sel) + 1) ? "R4" : "R2");
      if (rep_valid) begin
        head_seen = 1'b1;
        check(cyc == v, tag, "first valid cycle", cyc, v);
        check(int'(rep_data) == q_d[0], "R1", "replayed data", int'(rep_data), q_d[0]);
      end else if (cyc >= v) begin
        head_seen = 1'b1;
        check(1'b0, tag, "valid missing at due cycle", 0, v);
      end
    end else begin
      if (!rep_valid || int'(rep_data) != q_d[0])
        check(1'b0, "R5", "presented entry changed before accept", int'(rep_data), q_d[0]);
    end
  endtask

  // one clock: check outputs, drive inputs for the next edge, update model
  task automatic cycle(input bit cv, input logic [15:0] d, input logic [3:0] w,
                       input bit rdy, input bit fl);
    check_outputs();
    cap_valid = cv; cap_data = d; cap_wait = w; rep_ready = rdy; flush = fl;
    if (fl) begin
      q_d.delete(); q_w.delete(); q_k.delete();
      head_seen = 1'b0;
      a_prev = cyc + 1;
    end else begin
      if (rep_valid && rdy && q_d.size() > 0) begin
        void'(q_d.pop_front()); void'(q_w.pop_front()); void'(q_k.pop_front());
        head_seen = 1'b0;
        a_prev = cyc + 1;
      end
      if (cv && q_d.size() < DEPTH + 1) begin
        q_d.push_back(int'(d)); q_w.push_back(int'(w)); q_k.push_back(cyc + 1);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_flush(input int lag);
    lag_sel = 8'(lag);
    cycle(1'b0, 16'h0, 4'h0, 1'b1, 1'b1);
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && q_d.size() > 0; i++)
      cycle(1'b0, 16'h0, 4'h0, 1'b1, 1'b0);
    repeat (3) cycle(1'b0, 16'h0, 4'h0, 1'b1, 1'b0);
    check(q_d.size() == 0, "R1", "entries left undelivered", q_d.size(), 0);
  endtask

  task automatic run_random(input int lag, input int n);
    do_flush(lag);
    for (int i = 0; i < n; i++) begin
      bit cv;
      bit rdy;
      logic [3:0] w;
      cv  = ($urandom % 3 == 0) && (q_d.size() < 200);
      w   = ($urandom % 8 == 0) ? 4'd15 : 4'($urandom % 4);
      rdy = ($urandom % 4 != 0);
      cycle(cv, 16'($urandom), w, rdy, 1'b0);
    end
    drain(4000);
  endtask

  task summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1977));
    rst = 1'b1; cap_valid = 1'b0; cap_data = '0; cap_wait = '0;
    lag_sel = '0; flush = 1'b0; rep_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(rep_valid == 1'b0, "R8", "rep_valid in reset", int'(rep_valid), 0);
    check(overflow == 1'b0, "R8", "overflow in reset", int'(overflow), 0);
    rst = 1'b0;
    a_prev = cyc + 1;

    // R4 back-to-back zero-wait entries at lag 0
    do_flush(0);
    for (int i = 0; i < 3; i++) cycle(1'b1, 16'(16'h100 + i), 4'd0, 1'b1, 1'b0);
    drain(20);

    // R2 long lag, then R3 with wait states
    do_flush(60);
    cycle(1'b1, 16'hBEEF, 4'd0, 1'b1, 1'b0);
    cycle(1'b1, 16'hCAFE, 4'd5, 1'b1, 1'b0);
    drain(200);
    do_flush(3);
    cycle(1'b1, 16'h1234, 4'd15, 1'b1, 1'b0);
    drain(50);

    // R5 backpressure
    do_flush(0);
    cycle(1'b1, 16'hA5A5, 4'd0, 1'b0, 1'b0);
    cycle(1'b1, 16'h5A5A, 4'd2, 1'b0, 1'b0);
    repeat (20) cycle(1'b0, 16'h0, 4'd0, 1'b0, 1'b0);
    check(rep_valid == 1'b1 && rep_data == 16'hA5A5, "R5", "entry held under backpressure",
          int'(rep_data), 16'hA5A5);
    drain(50);

    // R7 flush with entries in flight
    do_flush(60);
    for (int i = 0; i < 5; i++) cycle(1'b1, 16'(16'h700 + i), 4'd1, 1'b1, 1'b0);
    repeat (10) cycle(1'b0, 16'h0, 4'd0, 1'b1, 1'b0);
    cycle(1'b0, 16'h0, 4'd0, 1'b1, 1'b1);
    check(rep_valid == 1'b0, "R7", "rep_valid after flush", int'(rep_valid), 0);
    repeat (100) cycle(1'b0, 16'h0, 4'd0, 1'b1, 1'b0);
    // R7 capture coincident with flush is discarded
    lag_sel = 8'd0;
    cycle(1'b1, 16'hDEAD, 4'd0, 1'b1, 1'b1);
    repeat (5) cycle(1'b0, 16'h0, 4'd0, 1'b1, 1'b0);
    check(rep_valid == 1'b0, "R7", "capture during flush replayed", int'(rep_valid), 0);
    // R7 ageing restarts for new captures
    cycle(1'b1, 16'h0F0F, 4'd0, 1'b1, 1'b0);
    drain(20);

    // R6 capacity and sticky overflow
    do_flush(0);
    for (int i = 0; i < DEPTH + 1; i++) cycle(1'b1, 16'(i * 3 + 1), 4'd0, 1'b0, 1'b0);
    check(overflow == 1'b0, "R6", "overflow before storage full", int'(overflow), 0);
    cycle(1'b1, 16'hFFFF, 4'd0, 1'b0, 1'b0);
    check(overflow == 1'b1, "R6", "overflow after dropped capture", int'(overflow), 1);
    drain(1000);
    check(overflow == 1'b1, "R6", "overflow sticks after drain", int'(overflow), 1);
    do_flush(0);
    check(overflow == 1'b1, "R6", "overflow sticks through flush", int'(overflow), 1);

    // random traffic at several lags
    run_random(0, 2000);
    run_random(3, 2000);
    run_random(60, 2000);
    run_random(255, 2000);

    // R8 final reset clears overflow
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(overflow == 1'b0, "R8", "overflow after reset", int'(overflow), 0);
    check(rep_valid == 1'b0, "R8", "rep_valid after reset", int'(rep_valid), 0);

    summary();
    $finish;
  end

endmodule